// File: doc/BRIEF.md
# Stopwatch Counter with Lap Modes

A synchronous stopwatch core. It takes a 32.768 kHz clock-enable, turns it into a steady hundredths-of-a-second tick, and keeps elapsed time as seven BCD digits covering 0:00:00.00 up to 9:59:59.99. After 9:59:59.99 the count rolls to zero and keeps running.

Three key inputs drive it. A start/stop key and a lap/reset key move a five-state mode controller through reset, running, stopped, lap and lap-stopped. A third key switches between two lap types. In standard lap the count keeps going while the display holds the lap time. In section lap, entering a lap also restarts the count from zero at that same edge. A two-bit test code turns the two main keys into direct adders for hours, minutes and seconds, so that any count can be reached quickly.

The outputs are the live count, the display value (frozen while a lap is shown, with an optional tenths-only view), the mode and the lap-type flag.

Top module: `sw_stopwatch`

## Requirements
- R1: `cnt_o` packs seven BCD digits, each 4 bits, from bit 27 down to bit 0: hours, tens of minutes, minutes, tens of seconds, seconds, tenths and hundredths. The digit limits are 9, 5, 9, 5, 9, 9 and 9. One hundredth after 9:59:59.99 the count reads 0:00:00.00 and keeps counting.
- R2: The hundredths tick comes from a fractional accumulator. Over any 32768 cycles with `tick_en_i` high outside reset mode there are exactly 100 ticks. The accumulator is held at zero while the mode is reset, so after a start, 32768 enabled cycles give exactly 0:00:01.00.
- R3: `mode_o` encoding is reset=0, run=1, stop=2, lap=3, lap-stop=4. The start key moves reset to run, run to stop, stop to run, lap to lap-stop and lap-stop to lap. Otherwise the lap key moves run to lap, lap to run, lap-stop to stop, and stop to reset with a zeroed count. If both keys rise in the same cycle, the start key wins.
- R4: The count advances on a tick only while the mode is run or lap.
- R5: In lap and lap-stop, `disp_o` shows the count captured on the run-to-lap edge. In every other mode it shows the live count.
- R6: With `tenth_sel_i` high, the hundredths digit `disp_o[3:0]` reads 0. `cnt_o` is unaffected.
- R7: A rising edge on `key_type_i` flips `section_o` (0 = standard, 1 = section) and never changes the count. With `section_o` = 1, the run-to-lap edge zeroes the count while `disp_o` shows the value from before the zeroing.
- R8: With `section_o` = 0, the run-to-lap edge does not alter the count.
- R9: A key acts only on the first cycle it is sampled high after being low. Holding a key has no further effect.
- R10: Reset (`rst_ni` low) or a synchronous `clr_i` gives mode reset, a zero count, a zero lap value, standard lap type and a zeroed accumulator.
- R11: While `test_i` is non-zero, key edges do not change the mode or the lap type. Key edges instead add to the count with carry into higher digits: code 1 start +10 s, lap +1 s; code 2 start +10 min, lap +1 min; code 3 lap +1 h. A tick and both additions in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 32.768 kHz enable pulse |
| clr_i | input | 1 | Synchronous all-clear |
| key_run_i | input | 1 | Start/stop key level |
| key_lap_i | input | 1 | Lap/reset key level |
| key_type_i | input | 1 | Lap-type toggle key level |
| tenth_sel_i | input | 1 | Show tenths only on the display |
| test_i | input | 2 | Test code, 0 for normal operation |
| cnt_o | output | 28 | Live BCD count |
| disp_o | output | 28 | Display BCD value |
| mode_o | output | 3 | Current mode |
| section_o | output | 1 | Lap type, 1 for section lap |

## Verification
Two additions can fall on the same clock edge as a hundredths tick. The bench keeps its own copy of the accumulator and waits until the next enabled cycle is bound to produce a tick. On exactly that cycle it raises both keys under test code 1. The result must equal the prior count plus one hundredth, ten seconds and one second, with carries taken modulo ten hours. A second coincidence has the section-lap entry meet a tick: the zeroing must override the tick while the display keeps the pre-zero value.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned NDIG = 7;
  localparam int unsigned DW   = 4;
  localparam int unsigned CW   = NDIG * DW;

  typedef enum logic [2:0] {
    M_RESET   = 3'd0,
    M_RUN     = 3'd1,
    M_STOP    = 3'd2,
    M_LAP     = 3'd3,
    M_LAPSTOP = 3'd4
  } mode_e;

  // digit order: 0 hundredths .. 6 hours
  function automatic logic [DW-1:0] dig_max(int unsigned i);
    return (i == 3 || i == 5) ? DW'(5) : DW'(9);
  endfunction

  // add one unit at the one-hot digit position, rippling carry upward
  function automatic logic [CW-1:0] bcd_bump(logic [CW-1:0] v, logic [NDIG-1:0] at);
    logic [CW-1:0] r;
    logic          c;
    r = v;
    c = 1'b0;
    for (int unsigned i = 0; i < NDIG; i++) begin
      c = c | at[i];
      if (c) begin
        if (r[i*DW +: DW] == dig_max(i)) begin
          r[i*DW +: DW] = '0;
        end else begin
          r[i*DW +: DW] = r[i*DW +: DW] + 1'b1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int unsigned NUM = 100,
  parameter int unsigned DEN = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hold_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned AW = $clog2(DEN + NUM);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;

  assign sum    = acc_q + AW'(NUM);
  assign tick_o = en_i && !hold_i && (sum >= AW'(DEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i || hold_i) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= tick_o ? sum - AW'(DEN) : sum;
    end
  end
endmodule

// File: rtl/sw_mode_ctrl.sv
module sw_mode_ctrl
  import sw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  run_p_i,
  input  logic  lap_p_i,
  input  logic  type_p_i,
  output mode_e mode_o,
  output logic  section_o,
  output logic  zero_o,
  output logic  cap_o
);
  mode_e mode_q, mode_d;
  logic  section_q;

  always_comb begin
    mode_d = mode_q;
    zero_o = 1'b0;
    cap_o  = 1'b0;
    unique case (mode_q)
      M_RESET: if (run_p_i) mode_d = M_RUN;
      M_RUN: begin
        if (run_p_i) begin
          mode_d = M_STOP;
        end else if (lap_p_i) begin
          mode_d = M_LAP;
          cap_o  = 1'b1;
          zero_o = section_q;
        end
      end
      M_STOP: begin
        if (run_p_i) begin
          mode_d = M_RUN;
        end else if (lap_p_i) begin
          mode_d = M_RESET;
          zero_o = 1'b1;
        end
      end
      M_LAP: begin
        if (run_p_i)      mode_d = M_LAPSTOP;
        else if (lap_p_i) mode_d = M_RUN;
      end
      M_LAPSTOP: begin
        if (run_p_i)      mode_d = M_LAP;
        else if (lap_p_i) mode_d = M_STOP;
      end
      default: mode_d = M_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_RESET;
      section_q <= 1'b0;
    end else if (clr_i) begin
      mode_q    <= M_RESET;
      section_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (type_p_i) section_q <= ~section_q;
    end
  end

  assign mode_o    = mode_q;
  assign section_o = section_q;
endmodule

// File: rtl/sw_bcd_counter.sv
module sw_bcd_counter
  import sw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            zero_i,
  input  logic            tick_i,
  input  logic [NDIG-1:0] add_a_i,
  input  logic [NDIG-1:0] add_b_i,
  output logic [CW-1:0]   cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] s0, s1, s2;

  // tick and both test additions compose within one cycle
  always_comb begin
    s0 = bcd_bump(cnt_q, {{(NDIG-1){1'b0}}, tick_i});
    s1 = bcd_bump(s0, add_a_i);
    s2 = bcd_bump(s1, add_b_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || zero_i)  cnt_q <= '0;
    else                       cnt_q <= s2;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned TICK_NUM = 100,
  parameter int unsigned TICK_DEN = 32768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          clr_i,
  input  logic          key_run_i,
  input  logic          key_lap_i,
  input  logic          key_type_i,
  input  logic          tenth_sel_i,
  input  logic [1:0]    test_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] disp_o,
  output logic [2:0]    mode_o,
  output logic          section_o
);
  localparam int unsigned NKEY = 3;

  logic [NKEY-1:0] key_lvl, key_q, key_rise;
  logic            test_act;
  logic            run_p, lap_p, type_p;
  logic            tick, running, zero, cap;
  logic [NDIG-1:0] add_a, add_b;
  logic [CW-1:0]   cnt, lap_q, disp_base;
  mode_e           mode;

  assign key_lvl = {key_type_i, key_lap_i, key_run_i};

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[k] <= 1'b0;
      else         key_q[k] <= key_lvl[k];
    end
    assign key_rise[k] = key_lvl[k] & ~key_q[k];
  end

  assign test_act = |test_i;
  assign run_p    = key_rise[0] & ~test_act & ~clr_i;
  assign lap_p    = key_rise[1] & ~test_act & ~clr_i;
  assign type_p   = key_rise[2] & ~test_act & ~clr_i;

  function automatic logic [NDIG-1:0] add_pos(logic [1:0] code, logic lap_key);
    unique case (code)
      2'd1:    return lap_key ? NDIG'(1 << 2) : NDIG'(1 << 3);
      2'd2:    return lap_key ? NDIG'(1 << 4) : NDIG'(1 << 5);
      2'd3:    return lap_key ? NDIG'(1 << 6) : '0;
      default: return '0;
    endcase
  endfunction

  assign add_a = (test_act && key_rise[0]) ? add_pos(test_i, 1'b0) : '0;
  assign add_b = (test_act && key_rise[1]) ? add_pos(test_i, 1'b1) : '0;

  sw_mode_ctrl u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .run_p_i  (run_p),
    .lap_p_i  (lap_p),
    .type_p_i (type_p),
    .mode_o   (mode),
    .section_o(section_o),
    .zero_o   (zero),
    .cap_o    (cap)
  );

  sw_tick_gen #(
    .NUM(TICK_NUM),
    .DEN(TICK_DEN)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .hold_i(mode == M_RESET),
    .en_i  (tick_en_i),
    .tick_o(tick)
  );

  assign running = (mode == M_RUN) || (mode == M_LAP);

  sw_bcd_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .zero_i (zero),
    .tick_i (tick & running),
    .add_a_i(add_a),
    .add_b_i(add_b),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lap_q <= '0;
    else if (clr_i)  lap_q <= '0;
    else if (cap)    lap_q <= cnt;
  end

  always_comb begin
    disp_base = ((mode == M_LAP) || (mode == M_LAPSTOP)) ? lap_q : cnt;
    disp_o    = disp_base;
    if (tenth_sel_i) disp_o[DW-1:0] = '0;
  end

  assign cnt_o  = cnt;
  assign mode_o = mode;
endmodule

// File: rtl/sw_stopwatch_chk.sv
module sw_stopwatch_chk
  import sw_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          tenth_sel_i,
  input logic [1:0]    test_i,
  input logic [CW-1:0] cnt_o,
  input logic [CW-1:0] disp_o,
  input logic [2:0]    mode_o,
  input logic          section_o
);
  function automatic logic digits_ok(logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int unsigned i = 0; i < NDIG; i++)
      if (v[i*DW +: DW] > dig_max(i)) ok = 1'b0;
    return ok;
  endfunction

  a_r1_digits_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits_ok(cnt_o) && digits_ok(disp_o));

  a_r3_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mode_o == 3'd0 && cnt_o == '0 && !section_o));

  a_r11_test_locks_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i != 2'd0 && !clr_i) |=> ($stable(mode_o) && $stable(section_o)));

  a_r5_lap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && !clr_i) |=> (mode_o != 3'd3 || $stable(disp_o) || !$stable(tenth_sel_i)));

  a_r7_section_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && section_o && !clr_i) |=> (mode_o != 3'd3 || cnt_o == '0));
endmodule

bind sw_stopwatch sw_stopwatch_chk u_chk (.*);

// File: tb/sw_stopwatch_bench.sv
module sw_stopwatch_bench;
  localparam int TOT = 3600000;
  localparam int ACC_DEN = 32768;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_en = 1'b0, clr = 1'b0;
  logic k_run = 1'b0, k_lap = 1'b0, k_type = 1'b0, tenth = 1'b0;
  logic [1:0] test = 2'd0;
  logic [27:0] cnt_o, disp_o;
  logic [2:0]  mode_o;
  logic        section_o;

  int n_cmp = 0, n_bad = 0;
  int m_acc = 0, m_cnt = 0, m_lap = 0, m_mode = 0, m_sec = 0;
  bit p_run = 0, p_lap = 0, p_type = 0;
  logic [27:0] snap;

  always #10 clk = ~clk;

  sw_stopwatch u_sw_stopwatch (
    .clk_i(clk), .rst_ni(rst_ni), .tick_en_i(tick_en), .clr_i(clr),
    .key_run_i(k_run), .key_lap_i(k_lap), .key_type_i(k_type),
    .tenth_sel_i(tenth), .test_i(test),
    .cnt_o(cnt_o), .disp_o(disp_o), .mode_o(mode_o), .section_o(section_o)
  );

  function automatic logic [27:0] to_bcd(int v);
    int h, m, s, c, r;
    h = v / 360000; r = v % 360000;
    m = r / 6000;   r = r % 6000;
    s = r / 100;    c = r % 100;
    return {4'(h), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10), 4'(c / 10), 4'(c % 10)};
  endfunction

  task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit er, el, et, tk;
    int nc, nm;
    er = k_run & !p_run; el = k_lap & !p_lap; et = k_type & !p_type;
    tk = 0;
    if (clr) begin
      m_acc = 0; m_cnt = 0; m_lap = 0; m_mode = 0; m_sec = 0;
    end else begin
      if (m_mode == 0) m_acc = 0;
      else if (tick_en) begin
        m_acc += 100;
        if (m_acc >= ACC_DEN) begin m_acc -= ACC_DEN; tk = 1; end
      end
      nc = m_cnt; nm = m_mode;
      if ((m_mode == 1 || m_mode == 3) && tk) nc = (nc + 1) % TOT;
      if (test != 0) begin
        case (test)
          2'd1: begin if (er) nc = (nc + 1000) % TOT; if (el) nc = (nc + 100) % TOT; end
          2'd2: begin if (er) nc = (nc + 60000) % TOT; if (el) nc = (nc + 6000) % TOT; end
          default: begin if (el) nc = (nc + 360000) % TOT; end
        endcase
      end else begin
        case (m_mode)
          0: if (er) nm = 1;
          1: if (er) nm = 2;
             else if (el) begin nm = 3; m_lap = m_cnt; if (m_sec == 1) nc = 0; end
          2: if (er) nm = 1; else if (el) begin nm = 0; nc = 0; end
          3: if (er) nm = 4; else if (el) nm = 1;
          default: if (er) nm = 3; else if (el) nm = 2;
        endcase
        if (et) m_sec ^= 1;
      end
      m_cnt = nc; m_mode = nm;
    end
    p_run = k_run; p_lap = k_lap; p_type = k_type;
  endtask

  task automatic compare_all();
    logic [27:0] ed;
    ed = (m_mode == 3 || m_mode == 4) ? to_bcd(m_lap) : to_bcd(m_cnt);
    if (tenth) ed[3:0] = 4'd0;
    check("R4 count", cnt_o, to_bcd(m_cnt));
    check("R5 display", disp_o, ed);
    check("R3 mode", 28'(mode_o), 28'(m_mode));
    check("R7 lap type", 28'(section_o), 28'(m_sec));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2;
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic press(int k);
    if (k == 0) k_run = 1'b1; else if (k == 1) k_lap = 1'b1; else k_type = 1'b1;
    cyc();
    k_run = 1'b0; k_lap = 1'b0; k_type = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    check("R10 reset mode", 28'(mode_o), 28'd0);
    check("R10 reset count", cnt_o, 28'd0);
    check("R10 reset type", 28'(section_o), 28'd0);

    tick_en = 1'b1;
    // R2: exactly one second after start
    press(0);
    run(32767);
    check("R2 one second", cnt_o, 28'h0000100);
    press(0);
    // R9: held key acts once
    k_run = 1'b1;
    run(5);
    check("R9 held key", 28'(mode_o), 28'd1);
    k_run = 1'b0;
    run(700);
    // R5 / R8: standard lap entry
    snap = cnt_o;
    k_lap = 1'b1;
    cyc();
    check("R5 lap captured", disp_o, snap);
    check("R8 count kept", cnt_o, to_bcd(m_cnt));
    k_lap = 1'b0;
    run(900);
    press(0);
    run(400);
    press(1);
    check("R3 lapstop to stop", 28'(mode_o), 28'd2);
    press(1);
    check("R3 stop to reset", cnt_o, 28'd0);

    // R7: section lap
    press(2);
    check("R7 type flag", 28'(section_o), 28'd1);
    press(0);
    run(1500);
    snap = cnt_o;
    k_lap = 1'b1;
    cyc();
    check("R7 section zero", cnt_o, 28'd0);
    check("R7 section display", disp_o, snap);
    k_lap = 1'b0;
    run(1000);
    press(2);
    check("R7 toggle keeps count", cnt_o, to_bcd(m_cnt));
    check("R7 back to standard", 28'(section_o), 28'd0);
    press(1);
    // sparse enable pattern
    for (int i = 0; i < 3000; i++) begin
      tick_en = (i % 3 == 0);
      cyc();
    end
    tick_en = 1'b1;
    press(0);
    tenth = 1'b1;
    cyc();
    check("R6 tenth digit", 28'(disp_o[3:0]), 28'd0);
    check("R6 count intact", cnt_o, to_bcd(m_cnt));
    tenth = 1'b0;

    // R10: clear while running
    press(0);
    run(100);
    clr = 1'b1;
    cyc();
    clr = 1'b0;
    check("R10 clear mode", 28'(mode_o), 28'd0);
    check("R10 clear count", cnt_o, 28'd0);

    // R11: test additions up to 9:59:59.00
    test = 2'd3;
    for (int i = 0; i < 9; i++) press(1);
    press(2);
    press(0);
    check("R11 keys ignored mode", 28'(mode_o), 28'd0);
    check("R11 keys ignored type", 28'(section_o), 28'd0);
    test = 2'd2;
    for (int i = 0; i < 5; i++) press(0);
    for (int i = 0; i < 9; i++) press(1);
    test = 2'd1;
    for (int i = 0; i < 5; i++) press(0);
    for (int i = 0; i < 9; i++) press(1);
    check("R11 preset", cnt_o, 28'h9595900);
    test = 2'd0;
    cyc();
    // R1: wrap after one running second
    press(0);
    run(32767);
    check("R1 wrap to zero", cnt_o, 28'd0);
    check("R1 still running", 28'(mode_o), 28'd1);
    run(400);

    // R11: tick and two additions on one edge
    test = 2'd1;
    while (m_acc + 100 < ACC_DEN) cyc();
    snap = cnt_o;
    k_run = 1'b1; k_lap = 1'b1;
    cyc();
    check("R11 tick plus adds", cnt_o, to_bcd((m_cnt) % TOT));
    check("R11 sum of three", cnt_o, bcd_after(snap));
    k_run = 1'b0; k_lap = 1'b0;
    test = 2'd0;
    run(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [27:0] bcd_after(logic [27:0] b);
    int v;
    v = b[27:24] * 360000 + b[23:20] * 60000 + b[19:16] * 6000 + b[15:12] * 1000
      + b[11:8] * 100 + b[7:4] * 10 + b[3:0];
    return to_bcd((v + 1 + 1000 + 100) % TOT);
  endfunction
endmodule